// File: doc/BRIEF.md
# Configurable Output Pad Cell

This block models the output path of a single programmable I/O cell. Two internal signals enter a small output stage. Configuration bits set that stage to work either as a 2:1 multiplexer, which lets two signals take turns on one pad, or as a two-input logic gate with an optional inversion on each input. The result then passes through drive control, which turns the cell into an open-drain driver when that is configured. Drive control also lets a chip-wide three-state net float the pad, except while boundary-scan EXTEST is active. The pad value and the pad enable are registered on the output clock.

A slew indication sits next to the pad. It follows a per-cell fast-slew bit, except on the first activation of the output after configuration completes. From the startup-done pulse until the clock after the pad is first driven, the slew is held at the reduced setting. Slew is only a flag. Drive strength and edge timing are not modelled.

Top module: `pad_out_cell`

## Requirements
- R1: With `cfg_mode` = 00 (multiplexer), the stage result is `sig_b` when `sel` = 1 and `sig_a` when `sel` = 0. The inversion bits have no effect in this mode.
- R2: With `cfg_mode` = 01 or 11 (pass), the stage result is `sig_a ^ cfg_inv_a`.
- R3: With `cfg_mode` = 10 (gate), the stage operates on `A = sig_a ^ cfg_inv_a` and `B = sig_b ^ cfg_inv_b`. The `cfg_gate` field selects the gate: 00 gives A&B, 01 gives A|B, 10 gives A^B, and 11 gives A&B.
- R4: With `cfg_open_drain` = 1, `pad_val` is 0 and `pad_oe` is the effective enable AND NOT the stage result. A high result floats the pad and a low result drives 0.
- R5: With `cfg_open_drain` = 0, `pad_val` equals the stage result and `pad_oe` equals the effective enable. The effective enable is `pin_en` AND NOT the global override. Both outputs appear one clock after the inputs.
- R6: The global net counts as asserted when `cfg_gts_use` = 1 and `gts_in ^ cfg_gts_invert` = 1. While it is asserted, the next `pad_oe` is 0. With `cfg_gts_use` = 0, `gts_in` has no effect.
- R7: While `extest_active` = 1, the global net does not override the pad enable.
- R8: While no soft start is pending, `slew_fast` equals `cfg_fast`.
- R9: A `startup_done` pulse arms soft start. From the next clock on, `slew_fast` is 0 until one clock after `pad_oe` is first seen at 1. After that, `slew_fast` follows `cfg_fast` again.
- R10: While `rst_n` is low at a clock edge, `pad_oe` and `pad_val` become 0 and soft start is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Stage mode: 00 mux, 01/11 pass, 10 gate |
| cfg_gate | input | 2 | Gate select in gate mode |
| cfg_inv_a | input | 1 | Invert input A before the stage (pass and gate modes) |
| cfg_inv_b | input | 1 | Invert input B before the stage (gate mode) |
| cfg_open_drain | input | 1 | Open-drain emulation |
| cfg_fast | input | 1 | Per-cell fast slew option |
| cfg_gts_use | input | 1 | Cell obeys the global three-state net |
| cfg_gts_invert | input | 1 | Invert the sense of the global three-state input |
| sig_a | input | 1 | First output signal |
| sig_b | input | 1 | Second output signal |
| sel | input | 1 | Multiplexer select |
| pin_en | input | 1 | Per-pin output enable |
| gts_in | input | 1 | Global three-state input |
| extest_active | input | 1 | Boundary-scan EXTEST executing |
| startup_done | input | 1 | Single-cycle end-of-configuration pulse |
| pad_val | output | 1 | Registered pad data |
| pad_oe | output | 1 | Registered pad drive enable (0 = high impedance) |
| slew_fast | output | 1 | 1 = fast slew, 0 = reduced slew |

## Verification
The soft-start window is the hardest situation to reach from the ports. It exists only between a startup-done pulse and the clock after the first registered enable, and an ordinary sweep never enters it. The bench drives it on purpose. It holds the enable low with fast slew configured and pulses startup-done. It then confirms that the slew stays reduced through several idle cycles. After that it raises the enable and samples in exactly the cycle where the pad turns on, while slew is still reduced, and in the cycle after, when fast slew returns. It also re-toggles the enable to show that soft start does not re-arm.

// File: rtl/pad_cell_pkg.sv
// Shared encodings for the configurable output pad cell.
// Assumes two-bit mode and gate fields; widths are derived here.
package pad_cell_pkg;
    localparam int MODE_W = 2;
    localparam int GATE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_MUX      = 2'b00,
        MODE_PASS     = 2'b01,
        MODE_GATE     = 2'b10,
        MODE_PASS_ALT = 2'b11
    } out_mode_e;

    typedef enum logic [GATE_W-1:0] {
        GATE_AND     = 2'b00,
        GATE_OR      = 2'b01,
        GATE_XOR     = 2'b10,
        GATE_AND_ALT = 2'b11
    } gate_op_e;
endpackage

// File: rtl/pad_func_stage.sv
// Two-input output stage: a 2:1 multiplexer or a gate with optional
// input inversions. Purely combinational.
// Assumes inversions are ignored in multiplexer mode.
module pad_func_stage
    import pad_cell_pkg::*;
(
    input  out_mode_e mode,
    input  gate_op_e  gate,
    input  logic      inv_a,
    input  logic      inv_b,
    input  logic      a,
    input  logic      b,
    input  logic      sel,
    output logic      f
);
    logic a_i;
    logic b_i;

    // Apply the optional per-input inversions.
    always_comb begin
        a_i = a ^ inv_a;
        b_i = b ^ inv_b;
    end

    // Select the stage function.
    always_comb begin
        case (mode)
            MODE_MUX:  f = sel ? b : a;
            MODE_GATE: begin
                case (gate)
                    GATE_OR:  f = a_i | b_i;
                    GATE_XOR: f = a_i ^ b_i;
                    default:  f = a_i & b_i;
                endcase
            end
            default:   f = a_i;
        endcase
    end
endmodule

// File: rtl/pad_drive_ctrl.sv
// Drive control: global three-state override (yielding to EXTEST),
// per-pin enable and open-drain emulation. Produces next pad value
// and enable. Combinational; the top module registers the results.
module pad_drive_ctrl (
    input  logic f,
    input  logic open_drain,
    input  logic pin_en,
    input  logic gts_in,
    input  logic gts_invert,
    input  logic gts_use,
    input  logic extest_active,
    output logic val_d,
    output logic oe_d
);
    logic gts_asserted;
    logic override;
    logic en_eff;

    // Resolve the global net sense and whether it may override the pad.
    always_comb begin
        gts_asserted = gts_use & (gts_in ^ gts_invert);
        override     = gts_asserted & ~extest_active;
        en_eff       = pin_en & ~override;
    end

    // Open drain drives 0 with the data steering the enable.
    always_comb begin
        if (open_drain) begin
            val_d = 1'b0;
            oe_d  = en_eff & ~f;
        end else begin
            val_d = f;
            oe_d  = en_eff;
        end
    end
endmodule

// File: rtl/pad_softstart.sv
// Soft-start tracker: armed by a startup-done pulse, disarmed on the
// clock after the registered pad enable is seen high. Forces reduced
// slew while armed. Synchronous active-low reset disarms.
module pad_softstart (
    input  logic clk,
    input  logic rst_n,
    input  logic startup_done,
    input  logic oe_q,
    input  logic cfg_fast,
    output logic soft_q,
    output logic slew_fast
);
    // Arm on startup pulse, disarm after the first driven cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
        end else if (startup_done) begin
            soft_q <= 1'b1;
        end else if (soft_q && oe_q) begin
            soft_q <= 1'b0;
        end
    end

    // Reduced slew while soft start is pending.
    always_comb begin
        slew_fast = cfg_fast & ~soft_q;
    end
endmodule

// File: rtl/pad_out_cell.sv
// Output path of one programmable I/O cell: function stage, drive
// control and soft-start slew tracker, with registered pad value and
// enable. Reset (synchronous, active low) floats the pad.
module pad_out_cell
    import pad_cell_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [GATE_W-1:0] cfg_gate,
    input  logic              cfg_inv_a,
    input  logic              cfg_inv_b,
    input  logic              cfg_open_drain,
    input  logic              cfg_fast,
    input  logic              cfg_gts_use,
    input  logic              cfg_gts_invert,
    input  logic              sig_a,
    input  logic              sig_b,
    input  logic              sel,
    input  logic              pin_en,
    input  logic              gts_in,
    input  logic              extest_active,
    input  logic              startup_done,
    output logic              pad_val,
    output logic              pad_oe,
    output logic              slew_fast
);
    logic f;
    logic val_d;
    logic oe_d;
    logic soft_q;

    pad_func_stage u_stage (
        .mode  (out_mode_e'(cfg_mode)),
        .gate  (gate_op_e'(cfg_gate)),
        .inv_a (cfg_inv_a),
        .inv_b (cfg_inv_b),
        .a     (sig_a),
        .b     (sig_b),
        .sel   (sel),
        .f     (f)
    );

    pad_drive_ctrl u_drive (
        .f             (f),
        .open_drain    (cfg_open_drain),
        .pin_en        (pin_en),
        .gts_in        (gts_in),
        .gts_invert    (cfg_gts_invert),
        .gts_use       (cfg_gts_use),
        .extest_active (extest_active),
        .val_d         (val_d),
        .oe_d          (oe_d)
    );

    // Register pad value and enable on the output clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_val <= 1'b0;
            pad_oe  <= 1'b0;
        end else begin
            pad_val <= val_d;
            pad_oe  <= oe_d;
        end
    end

    pad_softstart u_soft (
        .clk          (clk),
        .rst_n        (rst_n),
        .startup_done (startup_done),
        .oe_q         (pad_oe),
        .cfg_fast     (cfg_fast),
        .soft_q       (soft_q),
        .slew_fast    (slew_fast)
    );
endmodule

// File: rtl/pad_out_cell_chk.sv
// Checker for pad_out_cell, attached by bind. Observes ports and the
// soft-start state; drives nothing.
module pad_out_cell_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_open_drain,
    input logic cfg_fast,
    input logic cfg_gts_use,
    input logic cfg_gts_invert,
    input logic pin_en,
    input logic gts_in,
    input logic extest_active,
    input logic startup_done,
    input logic soft_q,
    input logic pad_val,
    input logic pad_oe,
    input logic slew_fast
);
    // R4
    od_val_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_open_drain |=> !pad_val);

    // R5
    pin_off_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |=> !pad_oe);

    // R6
    gts_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_gts_use && (gts_in ^ cfg_gts_invert) && !extest_active) |=> !pad_oe);

    // R7
    extest_keeps_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (extest_active && pin_en && !cfg_open_drain) |=> pad_oe);

    // R8
    slow_cfg_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fast |-> !slew_fast);

    // R9
    arm_reduces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        startup_done |=> !slew_fast);

    // R9
    disarm_after_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_q && pad_oe && !startup_done) |=> !soft_q);
endmodule

bind pad_out_cell pad_out_cell_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_open_drain (cfg_open_drain),
    .cfg_fast       (cfg_fast),
    .cfg_gts_use    (cfg_gts_use),
    .cfg_gts_invert (cfg_gts_invert),
    .pin_en         (pin_en),
    .gts_in         (gts_in),
    .extest_active  (extest_active),
    .startup_done   (startup_done),
    .soft_q         (soft_q),
    .pad_val        (pad_val),
    .pad_oe         (pad_oe),
    .slew_fast      (slew_fast)
);

// File: tb/pad_out_cell_bench.sv
// Bench: exhaustive sweep of every configuration and input combination,
// then the soft-start sequence. Expected values computed here.
module pad_out_cell_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_mode, cfg_gate;
    logic       cfg_inv_a, cfg_inv_b, cfg_open_drain, cfg_fast;
    logic       cfg_gts_use, cfg_gts_invert;
    logic       sig_a, sig_b, sel, pin_en, gts_in, extest_active, startup_done;
    logic       pad_val, pad_oe, slew_fast;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    pad_out_cell u_pad_out_cell (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_gate(cfg_gate),
        .cfg_inv_a(cfg_inv_a), .cfg_inv_b(cfg_inv_b),
        .cfg_open_drain(cfg_open_drain), .cfg_fast(cfg_fast),
        .cfg_gts_use(cfg_gts_use), .cfg_gts_invert(cfg_gts_invert),
        .sig_a(sig_a), .sig_b(sig_b), .sel(sel), .pin_en(pin_en),
        .gts_in(gts_in), .extest_active(extest_active),
        .startup_done(startup_done),
        .pad_val(pad_val), .pad_oe(pad_oe), .slew_fast(slew_fast)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    function automatic logic model_f(input logic [1:0] m, input logic [1:0] g,
                                     input logic ia, input logic ib,
                                     input logic a, input logic b, input logic s);
        logic af = (a != ia);
        logic bf = (b != ib);
        if (m == 2'd0) return s ? b : a;
        if (m == 2'd2) begin
            if (g == 2'd1) return (af || bf);
            if (g == 2'd2) return (af != bf);
            return (af && bf);
        end
        return af;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_mode = 0; cfg_gate = 0; cfg_inv_a = 0; cfg_inv_b = 0;
        cfg_open_drain = 0; cfg_fast = 1; cfg_gts_use = 0; cfg_gts_invert = 0;
        sig_a = 1; sig_b = 0; sel = 0; pin_en = 1; gts_in = 0;
        extest_active = 0; startup_done = 0;
        repeat (3) @(negedge clk);
        // R10: reset floats the pad, soft start disarmed
        check("R10", "pad_oe in reset", pad_oe, 1'b0);
        check("R10", "pad_val in reset", pad_val, 1'b0);
        check("R10", "slew_fast in reset", slew_fast, 1'b1);
        rst_n = 1;

        for (int i = 0; i < 65536; i++) begin
            logic ef, gon, ovr, en, ev, eo;
            string rv, ro;
            cfg_mode       = i[1:0];
            cfg_gate       = i[3:2];
            cfg_inv_a      = i[4];
            cfg_inv_b      = i[5];
            cfg_open_drain = i[6];
            cfg_fast       = i[7];
            cfg_gts_use    = i[8];
            cfg_gts_invert = i[9];
            sig_a          = i[10];
            sig_b          = i[11];
            sel            = i[12];
            pin_en         = i[13];
            gts_in         = i[14];
            extest_active  = i[15];
            ef  = model_f(cfg_mode, cfg_gate, cfg_inv_a, cfg_inv_b, sig_a, sig_b, sel);
            gon = cfg_gts_use && (gts_in != cfg_gts_invert);
            ovr = gon && !extest_active;
            en  = pin_en && !ovr;
            ev  = cfg_open_drain ? 1'b0 : ef;
            eo  = cfg_open_drain ? (en && !ef) : en;
            if (cfg_open_drain)     rv = "R4";
            else if (cfg_mode == 0) rv = "R1";
            else if (cfg_mode == 2) rv = "R3";
            else                    rv = "R2";
            if (ovr)                ro = "R6";
            else if (gon)           ro = "R7";
            else if (cfg_open_drain) ro = "R4";
            else                    ro = "R5";
            @(negedge clk);
            check(rv, $sformatf("pad_val case %0d", i), pad_val, ev);
            check(ro, $sformatf("pad_oe case %0d", i), pad_oe, eo);
            if (i[15:8] == 0)
                check("R8", $sformatf("slew_fast case %0d", i), slew_fast, cfg_fast);
        end

        // Soft-start sequence (R9)
        cfg_mode = 2'd1; cfg_inv_a = 0; sig_a = 1; cfg_open_drain = 0;
        cfg_gts_use = 0; extest_active = 0; cfg_fast = 1; pin_en = 0;
        @(negedge clk);
        check("R8", "slew before arming", slew_fast, 1'b1);
        startup_done = 1;
        @(negedge clk);
        startup_done = 0;
        check("R9", "slew reduced after startup pulse", slew_fast, 1'b0);
        repeat (4) @(negedge clk);
        check("R9", "slew reduced while pad idle", slew_fast, 1'b0);
        check("R9", "pad still off", pad_oe, 1'b0);
        pin_en = 1;
        @(negedge clk);
        check("R9", "pad turns on", pad_oe, 1'b1);
        check("R9", "slew reduced on first activation", slew_fast, 1'b0);
        @(negedge clk);
        check("R9", "fast slew after first activation", slew_fast, 1'b1);
        pin_en = 0;
        @(negedge clk);
        pin_en = 1;
        @(negedge clk);
        check("R9", "pad on again", pad_oe, 1'b1);
        check("R9", "no re-arm on second activation", slew_fast, 1'b1);
        cfg_fast = 0;
        @(negedge clk);
        check("R8", "slow option after soft start", slew_fast, 1'b0);

        // R10: reset mid-operation disarms a pending soft start
        cfg_fast = 1; pin_en = 0; startup_done = 1;
        @(negedge clk);
        startup_done = 0; rst_n = 0;
        @(negedge clk);
        check("R10", "reset disarms soft start", slew_fast, 1'b1);
        check("R10", "reset floats pad", pad_oe, 1'b0);
        rst_n = 1;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule